// File: doc/BRIEF.md
# DRAM Self-Refresh Entry/Exit Sequencer

This block sits in a memory controller and takes a DDR3-class device into self-refresh and back out. Two requests come from the rest of the controller: one asks to enter self-refresh and one asks to leave it. The block keeps a request that it cannot serve yet and acts on it later. It drives the device command slot, the device clock enable and the termination control. It also drives an enable that lets the clock generator stop the device clock while the device refreshes itself.

Entry waits until the controller reports that every bank is precharged and idle, that the precharge time has run out and that no burst is moving. If either termination setting is on, the block first drops termination for one cycle. It then issues REFRESH in the same cycle as it pulls the clock enable low, and issues a NOP in the cycle after. The device must stay in self-refresh for a programmable minimum time. If the clock is stopped, two further limits apply: the stop may begin only a set time after entry, and the clock must run again for a set time before the block raises the clock enable.

Once the clock enable is high, two wait timers start on the same edge. When the shorter one runs out, the block opens a gate for commands that do not need a locked DLL. When the longer one runs out, it opens a second gate for commands that do. All times are inputs, counted in controller clock cycles.

Top module: `sr_seq`

## Requirements
- R1: After reset the status is 0 (idle), the clock enable is 1, the command is DES (code 0), the clock-stop enable is 0, both command gates are 1, and termination follows `odt_req`.
- R2: An entry request is served only while `banks_idle`=1, `trp_met`=1 and `burst_busy`=0. A request made while any of these is not met is remembered and served on the first cycle in which all three hold.
- R3: When `rtt_nom_en` or `rtt_wr_en` is 1, exactly one cycle with termination 0, clock enable 1 and command NOP (code 1) comes before the REFRESH. When both are 0, the REFRESH comes in the first cycle after the entry decision. From that cycle until the block is back in idle or ready, termination is driven 0.
- R4: The entry command is REFRESH (code 2), issued in the same cycle as the clock enable goes to 0. The next cycle carries NOP. After that the command is DES for the rest of the stay in self-refresh.
- R5: The clock enable stays 0 for at least `t_low_min` cycles, counting the REFRESH cycle. An exit request that arrives earlier is held and served on the first cycle allowed.
- R6: `clk_stop_en` is 1 only in the residency phase, only when `cfg_clk_stop`=1, only once at least `t_stop_after` cycles have passed since the REFRESH cycle, and only when no exit is requested or pending. It drops in the same cycle as an exit request arrives.
- R7: If the clock was stopped during this stay, `clk_stop_en` stays 0 for at least `t_run_before` cycles before the first cycle with the clock enable at 1.
- R8: Take cycle m as the first cycle with the clock enable at 1. The command from cycle m onward is NOP until the wait ends, and `ok_nodll` is 0 from cycle m up to cycle m+`t_wait_fast` and is 1 from cycle m+`t_wait_fast`+1.
- R9: `ok_dll` is 0 from cycle m up to cycle m+`t_wait_dll` and is 1 from cycle m+`t_wait_dll`+1. Once both gates are open, the status moves to ready.
- R10: The status codes are 0 idle, 1 entering, 2 in self-refresh, 3 exiting and 4 ready. Ready behaves like idle, so a new entry may start from it.
- R11: An exit request made while the status is idle or ready has no effect. It is not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to enter self-refresh |
| exit_req | input | 1 | Request to leave self-refresh |
| banks_idle | input | 1 | All banks are precharged and idle |
| trp_met | input | 1 | Precharge time has elapsed since the last precharge |
| burst_busy | input | 1 | A data burst is in progress |
| rtt_nom_en | input | 1 | Nominal termination setting is enabled |
| rtt_wr_en | input | 1 | Write termination setting is enabled |
| odt_req | input | 1 | Termination value that normal traffic asks for |
| cfg_clk_stop | input | 1 | Allow the device clock to stop during self-refresh |
| t_low_min | input | TW | Minimum cycles with the clock enable low |
| t_stop_after | input | TW | Cycles after entry before the clock may stop |
| t_run_before | input | TW | Running-clock cycles required before exit |
| t_wait_fast | input | TW | Post-exit wait for commands that need no DLL lock |
| t_wait_dll | input | TW | Post-exit wait for commands that need DLL lock |
| cmd | output | 2 | Command slot: 0 DES, 1 NOP, 2 REFRESH |
| dram_clk_en | output | 1 | Device clock enable |
| dram_term | output | 1 | Device termination control |
| clk_stop_en | output | 1 | Device clock may be stopped |
| ok_nodll | output | 1 | Commands that need no DLL lock are allowed |
| ok_dll | output | 1 | Commands that need DLL lock are allowed |
| status | output | 3 | Sequencer status code |

## Verification
The bench targets requests that arrive at awkward times. These include an exit requested during the REFRESH cycle, which must wait out the minimum residency; a design that dropped it would stay in self-refresh for good. They also include an exit requested in the cycle after the clock stopped, which must still give the clock its full running time. A design that counted the running time from the request would raise the clock enable too early. The bench covers entry with termination on and off, where a missing or extra NOP cycle moves the REFRESH by one cycle. It also sets the two post-exit waits to different values, so a design that swapped them or started them one edge off opens a gate in the wrong cycle. It also checks that an exit request made while idle is ignored and that an entry request made while a burst runs is kept until the burst ends.

// File: rtl/sr_pkg.sv
package sr_pkg;

   typedef enum logic [1:0] {
      CMD_DES = 2'd0,
      CMD_NOP = 2'd1,
      CMD_REF = 2'd2
   } cmd_e;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_TOFF  = 3'd1,
      S_ISSUE = 3'd2,
      S_GUARD = 3'd3,
      S_HOLD  = 3'd4,
      S_WAKE  = 3'd5,
      S_READY = 3'd6
   } state_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ENTER = 3'd1,
      ST_SR    = 3'd2,
      ST_EXIT  = 3'd3,
      ST_READY = 3'd4
   } status_e;

   function automatic logic in_selfref(state_e s);
      return (s == S_ISSUE) || (s == S_GUARD) || (s == S_HOLD);
   endfunction

   function automatic logic is_normal(state_e s);
      return (s == S_IDLE) || (s == S_READY);
   endfunction

endpackage

// File: rtl/sr_sat_ctr.sv
module sr_sat_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (W < 1) begin : g_bad_w
      $error("sr_sat_ctr: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (clr)
         q <= '0;
      else if (inc && (q != TOP))
         q <= q + 1'b1;
   end

endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
   import sr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   enter_req,
   input  logic   exit_req,
   input  logic   pre_ok,
   input  logic   term_on,
   input  logic   exit_timing_ok,
   input  logic   wake_done,
   output state_e state,
   output logic   exit_want
);

   state_e nxt;
   logic   ent_q, ext_q;
   logic   ent_want;

   assign ent_want  = ent_q | enter_req;
   assign exit_want = ext_q | (exit_req & ((state == S_TOFF) | in_selfref(state)));

   always_comb begin
      nxt = state;
      unique case (state)
         S_IDLE, S_READY: begin
            if (ent_want && pre_ok)
               nxt = term_on ? S_TOFF : S_ISSUE;
         end
         S_TOFF:  if (pre_ok) nxt = S_ISSUE;
         S_ISSUE: nxt = S_GUARD;
         S_GUARD: nxt = S_HOLD;
         S_HOLD:  if (exit_want && exit_timing_ok) nxt = S_WAKE;
         S_WAKE:  if (wake_done) nxt = S_READY;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         ent_q <= 1'b0;
         ext_q <= 1'b0;
      end else begin
         state <= nxt;
         ent_q <= (nxt == S_ISSUE) ? 1'b0 : ent_want;
         ext_q <= (nxt == S_WAKE) ? 1'b0 : exit_want;
      end
   end

   // R4
   guard_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_ISSUE |=> state == S_GUARD);

   // R2
   entry_needs_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_normal(state) && !pre_ok) |=> is_normal(state));

endmodule

// File: rtl/sr_seq.sv
module sr_seq
   import sr_pkg::*;
#(
   parameter int TW             = 8,
   parameter bit ALLOW_CLK_STOP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enter_req,
   input  logic          exit_req,
   input  logic          banks_idle,
   input  logic          trp_met,
   input  logic          burst_busy,
   input  logic          rtt_nom_en,
   input  logic          rtt_wr_en,
   input  logic          odt_req,
   input  logic          cfg_clk_stop,
   input  logic [TW-1:0] t_low_min,
   input  logic [TW-1:0] t_stop_after,
   input  logic [TW-1:0] t_run_before,
   input  logic [TW-1:0] t_wait_fast,
   input  logic [TW-1:0] t_wait_dll,
   output logic [1:0]    cmd,
   output logic          dram_clk_en,
   output logic          dram_term,
   output logic          clk_stop_en,
   output logic          ok_nodll,
   output logic          ok_dll,
   output logic [2:0]    status
);

   localparam int CW = TW + 1;

   if (TW < 2) begin : g_bad_tw
      $error("sr_seq: TW must be at least 2");
   end

   state_e       state;
   logic         exit_want;
   logic         pre_ok, term_on;
   logic         in_sr;
   logic [CW-1:0] res_q, stab_q, post_q;
   logic [CW:0]   res_p1, stab_p1;
   logic         stopped_q;
   logic         low_ok, run_ok, stop_age_ok;
   logic         exit_timing_ok, wake_done;
   logic         fast_open, dll_open;
   logic         stop_raw;

   assign pre_ok  = banks_idle & trp_met & ~burst_busy;
   assign term_on = rtt_nom_en | rtt_wr_en;
   assign in_sr   = in_selfref(state);

   sr_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .enter_req      (enter_req),
      .exit_req       (exit_req),
      .pre_ok         (pre_ok),
      .term_on        (term_on),
      .exit_timing_ok (exit_timing_ok),
      .wake_done      (wake_done),
      .state          (state),
      .exit_want      (exit_want)
   );

   // cycles since the REFRESH cycle (0 in that cycle)
   sr_sat_ctr #(.W(CW)) u_res (
      .clk (clk), .rst_n (rst_n), .clr (~in_sr), .inc (1'b1), .q (res_q)
   );

   // running-clock cycles since the last stopped cycle
   sr_sat_ctr #(.W(CW)) u_stab (
      .clk (clk), .rst_n (rst_n), .clr (clk_stop_en), .inc (1'b1), .q (stab_q)
   );

   // cycles since the clock enable went high
   sr_sat_ctr #(.W(CW)) u_post (
      .clk (clk), .rst_n (rst_n), .clr (state != S_WAKE), .inc (1'b1), .q (post_q)
   );

   assign res_p1  = {1'b0, res_q}  + {{CW{1'b0}}, 1'b1};
   assign stab_p1 = {1'b0, stab_q} + {{CW{1'b0}}, 1'b1};

   assign stop_age_ok = res_q >= {1'b0, t_stop_after};
   assign stop_raw    = (state == S_HOLD) & cfg_clk_stop & stop_age_ok & ~exit_want;

   if (ALLOW_CLK_STOP) begin : g_stop
      assign clk_stop_en = stop_raw;
   end else begin : g_nostop
      assign clk_stop_en = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         stopped_q <= 1'b0;
      else
         stopped_q <= in_sr ? (stopped_q | clk_stop_en) : 1'b0;
   end

   assign low_ok         = res_p1 >= {2'b00, t_low_min};
   assign run_ok         = ~stopped_q | (stab_p1 >= {2'b00, t_run_before});
   assign exit_timing_ok = low_ok & run_ok & ~clk_stop_en;

   assign fast_open = is_normal(state) | ((state == S_WAKE) & (post_q > {1'b0, t_wait_fast}));
   assign dll_open  = is_normal(state) | ((state == S_WAKE) & (post_q > {1'b0, t_wait_dll}));
   assign wake_done = fast_open & dll_open;

   assign ok_nodll    = fast_open;
   assign ok_dll      = dll_open;
   assign dram_clk_en = ~in_sr;
   assign dram_term   = is_normal(state) ? odt_req : 1'b0;

   always_comb begin
      unique case (state)
         S_ISSUE:                 cmd = CMD_REF;
         S_TOFF, S_GUARD, S_WAKE: cmd = CMD_NOP;
         default:                 cmd = CMD_DES;
      endcase
   end

   always_comb begin
      unique case (state)
         S_IDLE:                   status = ST_IDLE;
         S_TOFF, S_ISSUE, S_GUARD: status = ST_ENTER;
         S_HOLD:                   status = ST_SR;
         S_WAKE:                   status = ST_EXIT;
         S_READY:                  status = ST_READY;
         default:                  status = ST_IDLE;
      endcase
   end

   // Assertion-side counters, separate from the control path
   logic [CW-1:0] a_low_run, a_run_since;
   logic          a_saw_stop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_low_run   <= '0;
         a_run_since <= '0;
         a_saw_stop  <= 1'b0;
      end else begin
         a_low_run   <= dram_clk_en ? '0 :
                        ((a_low_run == {CW{1'b1}}) ? a_low_run : a_low_run + 1'b1);
         a_run_since <= clk_stop_en ? '0 :
                        ((a_run_since == {CW{1'b1}}) ? a_run_since : a_run_since + 1'b1);
         a_saw_stop  <= dram_clk_en ? 1'b0 : (a_saw_stop | clk_stop_en);
      end
   end

   // R4
   ref_with_low_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_REF |-> (!dram_clk_en && !dram_term));

   // R4
   nop_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_REF |=> cmd == CMD_NOP);

   // R5
   min_low_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_clk_en) |-> a_low_run >= {1'b0, t_low_min});

   // R6
   stop_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop_en |-> (!dram_clk_en && !exit_req));

   // R7
   run_before_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dram_clk_en) && a_saw_stop) |-> a_run_since >= {1'b0, t_run_before});

   // R8
   gates_shut_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_clk_en) |-> (!ok_nodll && !ok_dll && cmd == CMD_NOP));

endmodule

// File: tb/sr_seq_bench.sv
module sr_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enter_req = 0, exit_req = 0, banks_idle = 0, trp_met = 0, burst_busy = 0;
   logic rtt_nom_en = 0, rtt_wr_en = 0, odt_req = 1, cfg_clk_stop = 0;
   logic [TW-1:0] t_low_min = 6, t_stop_after = 4, t_run_before = 3;
   logic [TW-1:0] t_wait_fast = 5, t_wait_dll = 12;
   logic [1:0] cmd;
   logic dram_clk_en, dram_term, clk_stop_en, ok_nodll, ok_dll;
   logic [2:0] status;

   int checks = 0, errors = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sr_seq #(.TW(TW), .ALLOW_CLK_STOP(1'b1)) u_sr_seq (
      .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
      .banks_idle(banks_idle), .trp_met(trp_met), .burst_busy(burst_busy),
      .rtt_nom_en(rtt_nom_en), .rtt_wr_en(rtt_wr_en), .odt_req(odt_req),
      .cfg_clk_stop(cfg_clk_stop), .t_low_min(t_low_min), .t_stop_after(t_stop_after),
      .t_run_before(t_run_before), .t_wait_fast(t_wait_fast), .t_wait_dll(t_wait_dll),
      .cmd(cmd), .dram_clk_en(dram_clk_en), .dram_term(dram_term),
      .clk_stop_en(clk_stop_en), .ok_nodll(ok_nodll), .ok_dll(ok_dll), .status(status)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   // Reference model: phase 0 idle,1 term-off,2 refresh,3 guard nop,4 resident,5 waking,6 ready
   int  ph = 0, age = 0, run = 0, post = 0;
   bit  ent_p = 0, ext_p = 0, was_stop = 0;

   function automatic bit m_want_x();
      return ext_p || (exit_req && ph >= 1 && ph <= 4);
   endfunction
   function automatic bit m_stop();
      return ph == 4 && cfg_clk_stop && age >= int'(t_stop_after) && !m_want_x();
   endfunction
   function automatic bit m_norm();
      return ph == 0 || ph == 6;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; age = 0; run = 0; post = 0; ent_p = 0; ext_p = 0; was_stop = 0;
      end else begin
         int  nph;
         bit  st, wx, we, pre;
         st  = m_stop();
         wx  = m_want_x();
         we  = ent_p || enter_req;
         pre = banks_idle && trp_met && !burst_busy;
         nph = ph;
         if (m_norm()) begin
            if (we && pre) nph = (rtt_nom_en || rtt_wr_en) ? 1 : 2;
         end else if (ph == 1) begin
            if (pre) nph = 2;
         end else if (ph == 2 || ph == 3) begin
            nph = ph + 1;
         end else if (ph == 4) begin
            if (wx && age + 1 >= int'(t_low_min) &&
                (!was_stop || run + 1 >= int'(t_run_before)) && !st) nph = 5;
         end else if (ph == 5) begin
            if (post > int'(t_wait_fast) && post > int'(t_wait_dll)) nph = 6;
         end
         ent_p    = (nph == 2) ? 0 : we;
         ext_p    = (nph == 5) ? 0 : wx;
         was_stop = (ph >= 2 && ph <= 4) ? (was_stop || st) : 0;
         age      = (ph >= 2 && ph <= 4) ? age + 1 : 0;
         run      = st ? 0 : run + 1;
         post     = (ph == 5) ? post + 1 : 0;
         ph       = nph;
      end
   end

   // Per-cycle comparison and directed timing monitors
   bit prev_cke = 1, saw_stop = 0, prev_fast = 1, prev_dll = 1;
   int low_cnt = 0, run_cnt = 0, rise_cyc = 0;

   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         int es;
         es = (ph == 0) ? 0 : (ph <= 3) ? 1 : (ph == 4) ? 2 : (ph == 5) ? 3 : 4;
         chk("R10 status", int'(status), es);
         chk("R5 clock enable", int'(dram_clk_en), (ph >= 2 && ph <= 4) ? 0 : 1);
         chk("R4 command", int'(cmd), (ph == 2) ? 2 : (ph == 1 || ph == 3 || ph == 5) ? 1 : 0);
         chk("R3 termination", int'(dram_term), m_norm() ? int'(odt_req) : 0);
         chk("R6 clock stop", int'(clk_stop_en), int'(m_stop()));
         chk("R8 fast gate", int'(ok_nodll),
             m_norm() ? 1 : (ph == 5 && post > int'(t_wait_fast)) ? 1 : 0);
         chk("R9 dll gate", int'(ok_dll),
             m_norm() ? 1 : (ph == 5 && post > int'(t_wait_dll)) ? 1 : 0);
         if (dram_clk_en && !prev_cke) begin
            chk("R5 low span ok", int'(low_cnt >= int'(t_low_min)), 1);
            if (saw_stop) chk("R7 running span ok", int'(run_cnt >= int'(t_run_before)), 1);
            saw_stop = 0;
            rise_cyc = cyc;
         end
         if (ok_nodll && !prev_fast)
            chk("R8 fast gate delay", cyc - rise_cyc, int'(t_wait_fast) + 1);
         if (ok_dll && !prev_dll)
            chk("R9 dll gate delay", cyc - rise_cyc, int'(t_wait_dll) + 1);
         low_cnt  = dram_clk_en ? 0 : low_cnt + 1;
         if (clk_stop_en) begin saw_stop = 1; run_cnt = 0; end
         else run_cnt = run_cnt + 1;
         prev_cke  = dram_clk_en;
         prev_fast = ok_nodll;
         prev_dll  = ok_dll;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_enter();
      @(negedge clk); enter_req = 1;
      @(negedge clk); enter_req = 0;
   endtask

   task automatic pulse_exit();
      @(negedge clk); exit_req = 1;
      @(negedge clk); exit_req = 0;
   endtask

   task automatic wait_status(int code);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk); #3;
         if (int'(status) == code) return;
      end
      chk("R10 status reached", int'(status), code);
   endtask

   initial begin
      cycles(3);
      rst_n = 1;
      @(negedge clk); #3;
      // R1 reset state
      chk("R1 status", int'(status), 0);
      chk("R1 clock enable", int'(dram_clk_en), 1);
      chk("R1 command", int'(cmd), 0);
      chk("R1 gates", int'({ok_nodll, ok_dll}), 3);
      chk("R1 clock stop", int'(clk_stop_en), 0);

      // R11 exit request while idle is ignored
      pulse_exit();
      cycles(2); #3;
      chk("R11 idle after stray exit", int'(status), 0);

      // R2 entry held while preconditions fail; termination on (R3); clock stop allowed
      rtt_nom_en = 1; cfg_clk_stop = 1;
      pulse_enter();
      cycles(4); #3;
      chk("R2 entry held", int'(status), 0);
      banks_idle = 1; trp_met = 1;
      wait_status(2);
      cycles(8);
      pulse_exit();
      wait_status(4);

      // Exit requested during the REFRESH cycle, no clock stop, termination off
      cfg_clk_stop = 0; rtt_nom_en = 0;
      @(negedge clk); enter_req = 1;
      @(negedge clk); enter_req = 0; exit_req = 1;
      @(negedge clk); exit_req = 0;
      wait_status(4);

      // Entry from ready held by a burst; clock stop with exit right after the stop
      burst_busy = 1; cfg_clk_stop = 1; rtt_wr_en = 1;
      t_wait_fast = 9; t_wait_dll = 3; t_run_before = 5;
      pulse_enter();
      cycles(3); #3;
      chk("R2 held by burst", int'(status), 4);
      burst_busy = 0;
      wait_status(2);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); #3;
         if (clk_stop_en) break;
      end
      chk("R6 clock stopped", int'(clk_stop_en), 1);
      pulse_exit();
      wait_status(4);
      cycles(3);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule